// File: doc/BRIEF.md
# Lock-in IQ Demodulator with Batch Decimation

This block recovers the in-phase and quadrature content of a stream of signed 16-bit samples against a local oscillator. It keeps a 32-bit wrapping phase accumulator and presents the phase for the next sample on `loPhase`. An external generator returns the cosine and sine of that phase. Each sample is mixed with the upper 16 bits of the cosine and sine components. Each of the two products then passes through its own cascaded first-order lowpass filter. Both filters use the same log2 time constant.

A `batchStart` strobe opens each batch. It loads the start phase as `phaseOffset + refPhase * harmonic` and the per-sample step as `refFreq * harmonic`, with all arithmetic modulo 2^32. A harmonic of -1 demodulates the fundamental of the reference. Every sample of a batch runs through the filters. Only the filter output after the last sample of each batch of 2^BATCH_LOG2 samples is presented, with a one-cycle `resultValid` pulse. The filter state carries over from one batch to the next and is cleared only by reset.

Top module: `lockin_demod`

## Requirements
- R1: After synchronous reset, `resultValid`, `iOut`, `qOut` and `loPhase` are 0. The step word, the batch count and all filter state are 0. The time constant is 8.
- R2: When `batchStart` is high at a clock edge, the block loads `loPhase` with `phaseOffset + refPhase*harmonic` and the step word with `refFreq*harmonic`, both modulo 2^32, where `harmonic` is signed. It also latches `timeConst` as k and clears the batch count. A sample offered in that same cycle is not consumed.
- R3: A sample is consumed at a clock edge where `sampleValid` and `loValid` are both high and `batchStart` is low. Each consumed sample advances `loPhase` by the step word, wrapping modulo 2^32.
- R4: While no sample is consumed, `loPhase` is unchanged, and `sampleValid` alone changes neither the filter state nor the outputs.
- R5: The in-phase mixer output is (sample × signed `loCos[31:16]`) arithmetically shifted right by 16. The quadrature mixer does the same with `loSin`.
- R6: Each channel is a cascade of ORDER stages, all using the same k. For each consumed sample, a stage with input x and state y computes d = x − (y >>> k), sets the new y to y + d, and outputs (new y − (d >>> 1)) >>> k, all in 32-bit signed arithmetic.
- R7: `resultValid` is high for exactly one cycle, in the cycle after the 2^BATCH_LOG2-th sample consumed since the last `batchStart` or reset. `iOut`/`qOut` then hold the filter outputs for that sample and keep those values until the next result.
- R8: Filter state is not cleared by `batchStart`. It carries over across batches.
- R9: Every k in 0..31 is accepted, including k = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| batchStart | input | 1 | Starts a batch and loads phase, step and k |
| phaseOffset | input | 32 | Phase offset added to the start phase |
| refPhase | input | 32 | Reference phase at the start of the batch |
| refFreq | input | 32 | Reference phase step per sample |
| harmonic | input | HARM_W | Signed harmonic multiplier |
| timeConst | input | 5 | Log2 filter time constant k |
| sampleValid | input | 1 | Sample present on `sample` |
| sample | input | 16 | Signed input sample |
| loPhase | output | 32 | Oscillator phase for the next sample |
| loValid | input | 1 | `loCos`/`loSin` match `loPhase` |
| loCos | input | 32 | Signed cosine of `loPhase` |
| loSin | input | 32 | Signed sine of `loPhase` |
| resultValid | output | 1 | One-cycle result strobe |
| iOut | output | 32 | Filtered in-phase result |
| qOut | output | 32 | Filtered quadrature result |

## Verification
The stimulus uses constant full-scale cosine with zero sine, mixed-sign samples with distinct cosine and sine, and k values of 8 and 0. These separate the two channels and a swap of cosine and sine, and expose shift and sign errors in the mixer and the filter. A harmonic of -1 and a harmonic of 3 with a step that wraps show whether the signed multiply and the modulo-2^32 accumulation are right. Offering a sample without `loValid`, and offering one together with `batchStart`, shows that nothing is consumed in either case. Two back-to-back batches without reset show that filter state is kept across batches.

// File: rtl/lockin_pkg.sv
package lockin_pkg;
  localparam int PHASE_W  = 32;
  localparam int SAMPLE_W = 16;
  localparam int ACC_W    = 32;
  localparam int K_W      = 5;

  typedef struct packed {
    logic load;   // batch start: load phase, step, k
    logic step;   // consume one sample
    logic emit;   // last sample of batch: present result
  } ctlStrobes_t;
endpackage

// File: rtl/lockin_ctrl.sv
module lockin_ctrl
  import lockin_pkg::*;
#(
  parameter int BATCH_LOG2 = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        batchStart,
  input  logic        sampleValid,
  input  logic        loValid,
  output ctlStrobes_t strobes
);
  localparam int CNT_W = (BATCH_LOG2 > 0) ? BATCH_LOG2 : 1;
  localparam int BATCH = 1 << BATCH_LOG2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BATCH - 1);

  logic [CNT_W-1:0] count;
  logic lastSample;

  assign lastSample   = (count == LAST);
  assign strobes.load = batchStart;
  assign strobes.step = sampleValid && loValid && !batchStart;
  assign strobes.emit = strobes.step && lastSample;

  always_ff @(posedge clk) begin
    if (rst || strobes.load) count <= '0;
    else if (strobes.step)   count <= lastSample ? '0 : count + 1'b1;
  end

  // R2: a batch start leaves the batch count at zero
  p_count_cleared_r2: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> (count == '0));

  // R4: without a consumed sample the batch count does not move
  p_count_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!strobes.step && !strobes.load) |=> $stable(count));
endmodule

// File: rtl/lockin_dpath.sv
module lockin_dpath
  import lockin_pkg::*;
#(
  parameter int HARM_W = 8,
  parameter int ORDER  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  ctlStrobes_t         strobes,
  input  logic [PHASE_W-1:0]  phaseOffset,
  input  logic [PHASE_W-1:0]  refPhase,
  input  logic [PHASE_W-1:0]  refFreq,
  input  logic [HARM_W-1:0]   harmonic,
  input  logic [K_W-1:0]      timeConst,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [PHASE_W-1:0]  loCos,
  input  logic [PHASE_W-1:0]  loSin,
  output logic [PHASE_W-1:0]  loPhase,
  output logic                resultValid,
  output logic [ACC_W-1:0]    iOut,
  output logic [ACC_W-1:0]    qOut
);
  localparam int HALF = PHASE_W / 2;
  localparam logic [K_W-1:0] K_RESET = K_W'(8);

  logic [PHASE_W-1:0] harmExt, startPhase, stepWord, freqWord;
  logic [K_W-1:0]     timeK;

  assign harmExt    = {{(PHASE_W-HARM_W){harmonic[HARM_W-1]}}, harmonic};
  assign startPhase = phaseOffset + refPhase * harmExt;
  assign stepWord   = refFreq * harmExt;

  always_ff @(posedge clk) begin
    if (rst) begin
      loPhase  <= '0;
      freqWord <= '0;
      timeK    <= K_RESET;
    end else if (strobes.load) begin
      loPhase  <= startPhase;
      freqWord <= stepWord;
      timeK    <= timeConst;
    end else if (strobes.step) begin
      loPhase  <= loPhase + freqWord;
    end
  end

  // Mixers: sample times the upper half of each oscillator component
  logic signed [ACC_W-1:0] mixed [2];
  assign mixed[0] = (ACC_W'($signed(sample)) * ACC_W'($signed(loCos[PHASE_W-1:HALF]))) >>> HALF;
  assign mixed[1] = (ACC_W'($signed(sample)) * ACC_W'($signed(loSin[PHASE_W-1:HALF]))) >>> HALF;

  logic signed [ACC_W-1:0] filtOut [2];

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic signed [ACC_W-1:0] xs [ORDER+1];
    assign xs[0] = mixed[ch];
    for (genvar st = 0; st < ORDER; st++) begin : g_stage
      logic signed [ACC_W-1:0] yQ, dy, yD;
      assign dy        = xs[st] - (yQ >>> timeK);
      assign yD        = yQ + dy;
      assign xs[st+1]  = (yD - (dy >>> 1)) >>> timeK;
      always_ff @(posedge clk) begin
        if (rst)               yQ <= '0;
        else if (strobes.step) yQ <= yD;
      end
    end
    assign filtOut[ch] = xs[ORDER];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultValid <= 1'b0;
      iOut        <= '0;
      qOut        <= '0;
    end else begin
      resultValid <= strobes.emit;
      if (strobes.emit) begin
        iOut <= filtOut[0];
        qOut <= filtOut[1];
      end
    end
  end

  // R4: phase is held while nothing is consumed or loaded
  p_phase_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!strobes.step && !strobes.load) |=> $stable(loPhase));

  // R3: each consumed sample moves the phase by the latched step
  p_phase_advance_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.step |=> (loPhase == $past(loPhase) + freqWord));

  // R7: a result strobe always follows a consumed sample
  p_result_after_step_r7: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> $past(strobes.step));

  // R7: outputs stay put between results
  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !strobes.emit |=> ($stable(iOut) && $stable(qOut)));
endmodule

// File: rtl/lockin_demod.sv
module lockin_demod
  import lockin_pkg::*;
#(
  parameter int BATCH_LOG2 = 2,
  parameter int HARM_W     = 8,
  parameter int ORDER      = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                batchStart,
  input  logic [PHASE_W-1:0]  phaseOffset,
  input  logic [PHASE_W-1:0]  refPhase,
  input  logic [PHASE_W-1:0]  refFreq,
  input  logic [HARM_W-1:0]   harmonic,
  input  logic [K_W-1:0]      timeConst,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [PHASE_W-1:0]  loPhase,
  input  logic                loValid,
  input  logic [PHASE_W-1:0]  loCos,
  input  logic [PHASE_W-1:0]  loSin,
  output logic                resultValid,
  output logic [ACC_W-1:0]    iOut,
  output logic [ACC_W-1:0]    qOut
);
  ctlStrobes_t strobes;

  lockin_ctrl #(.BATCH_LOG2(BATCH_LOG2)) u_ctrl (
    .clk(clk), .rst(rst), .batchStart(batchStart),
    .sampleValid(sampleValid), .loValid(loValid), .strobes(strobes)
  );

  lockin_dpath #(.HARM_W(HARM_W), .ORDER(ORDER)) u_dpath (
    .clk(clk), .rst(rst), .strobes(strobes),
    .phaseOffset(phaseOffset), .refPhase(refPhase), .refFreq(refFreq),
    .harmonic(harmonic), .timeConst(timeConst), .sample(sample),
    .loCos(loCos), .loSin(loSin), .loPhase(loPhase),
    .resultValid(resultValid), .iOut(iOut), .qOut(qOut)
  );
endmodule

// File: tb/lockin_demod_test.sv
module lockin_demod_test;
  localparam int PERIOD = 10;
  localparam int BATCH_LOG2 = 2;
  localparam int BATCH = 1 << BATCH_LOG2;
  localparam int HARM_W = 8;
  localparam int ORDER = 2;

  logic clk = 1'b0;
  logic rst, batchStart, sampleValid, loValid;
  logic [31:0] phaseOffset, refPhase, refFreq, loCos, loSin;
  logic [HARM_W-1:0] harmonic;
  logic [4:0] timeConst;
  logic [15:0] sample;
  logic [31:0] loPhase, iOut, qOut;
  logic resultValid;

  int nChecks = 0;
  int nFails  = 0;

  // reference model state
  logic signed [31:0] mY [2][ORDER];
  logic [31:0] mPhase, mFreq;
  logic [4:0]  mK;
  int          mCnt;
  logic signed [31:0] mI, mQ, lastI, lastQ;

  always #(PERIOD/2) clk = ~clk;

  lockin_demod #(.BATCH_LOG2(BATCH_LOG2), .HARM_W(HARM_W), .ORDER(ORDER)) uut (
    .clk(clk), .rst(rst), .batchStart(batchStart), .phaseOffset(phaseOffset),
    .refPhase(refPhase), .refFreq(refFreq), .harmonic(harmonic),
    .timeConst(timeConst), .sampleValid(sampleValid), .sample(sample),
    .loPhase(loPhase), .loValid(loValid), .loCos(loCos), .loSin(loSin),
    .resultValid(resultValid), .iOut(iOut), .qOut(qOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic signed [31:0] runChan(input int ch, input logic signed [31:0] xin);
    logic signed [31:0] x, d;
    x = xin;
    for (int st = 0; st < ORDER; st++) begin
      d = x - (mY[ch][st] >>> mK);
      mY[ch][st] = mY[ch][st] + d;
      x = (mY[ch][st] - (d >>> 1)) >>> mK;
    end
    return x;
  endfunction

  task automatic modelReset();
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < ORDER; s++) mY[c][s] = '0;
    mPhase = '0; mFreq = '0; mK = 5'd8; mCnt = 0; lastI = '0; lastQ = '0;
  endtask

  task automatic doReset();
    rst = 1'b1; batchStart = 1'b0; sampleValid = 1'b0; loValid = 1'b0;
    phaseOffset = '0; refPhase = '0; refFreq = '0; harmonic = '0;
    timeConst = 5'd3; sample = '0; loCos = '0; loSin = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    modelReset();
  endtask

  // R2: batch start, optionally with a sample offered in the same cycle
  task automatic startBatch(input logic [31:0] off, input logic [31:0] rp,
                            input logic [31:0] rf, input logic [HARM_W-1:0] h,
                            input logic [4:0] k, input bit withSample);
    logic [31:0] hx;
    batchStart = 1'b1; phaseOffset = off; refPhase = rp; refFreq = rf;
    harmonic = h; timeConst = k;
    if (withSample) begin
      sampleValid = 1'b1; loValid = 1'b1; sample = 16'h4000; loCos = 32'h7fff0000;
    end
    @(negedge clk);
    batchStart = 1'b0; sampleValid = 1'b0; loValid = 1'b0; timeConst = 5'd31;
    hx = {{(32-HARM_W){h[HARM_W-1]}}, h};
    mPhase = off + rp * hx; mFreq = rf * hx; mK = k; mCnt = 0;
    check("R2 start phase", loPhase, mPhase);
    check("R2 no result on start", {31'd0, resultValid}, 32'd0);
  endtask

  // R3 R5 R6 R7: consume one sample and check phase and result
  task automatic push(input logic [15:0] s, input logic [31:0] c, input logic [31:0] sn);
    logic signed [31:0] pi, pq;
    check("R3 phase before sample", loPhase, mPhase);
    sampleValid = 1'b1; loValid = 1'b1; sample = s; loCos = c; loSin = sn;
    @(negedge clk);
    sampleValid = 1'b0; loValid = 1'b0;
    pi = ($signed(s) * $signed(c[31:16])) >>> 16;
    pq = ($signed(s) * $signed(sn[31:16])) >>> 16;
    mI = runChan(0, pi);
    mQ = runChan(1, pq);
    mPhase = mPhase + mFreq;
    mCnt++;
    if (mCnt == BATCH) begin
      mCnt = 0; lastI = mI; lastQ = mQ;
      check("R7 result strobe", {31'd0, resultValid}, 32'd1);
      check("R5 R6 I result", iOut, mI);
      check("R5 R6 Q result", qOut, mQ);
    end else begin
      check("R7 no strobe mid batch", {31'd0, resultValid}, 32'd0);
      check("R7 outputs held", iOut, lastI);
    end
  endtask

  task automatic pushBatch(input int seed);
    for (int n = 0; n < BATCH; n++)
      push(16'(seed * 1237 + n * 4099 - 20000), 32'(seed * 7919 + n * 32'h1357_9bdf),
           32'(32'h8000_0000 + seed * 31 + n * 32'h2468_ace1));
  endtask

  task automatic testReset();
    doReset();
    check("R1 valid after reset", {31'd0, resultValid}, 32'd0);
    check("R1 I after reset", iOut, 32'd0);
    check("R1 Q after reset", qOut, 32'd0);
    check("R1 phase after reset", loPhase, 32'd0);
    // default k = 8, zero step: DC input through cosine only
    for (int n = 0; n < BATCH; n++) push(16'h7000, 32'h7fff_0000, 32'd0);
    check("R1 phase stays at zero step", loPhase, 32'd0);
  endtask

  task automatic testFundamental();
    startBatch(32'h4000_0000, 32'h1000_0000, 32'h0100_0000, 8'hff, 5'd8, 1'b0);
    check("R2 harmonic -1 phase", loPhase, 32'h3000_0000);
    pushBatch(1);
    check("R3 phase after batch", loPhase, 32'h3000_0000 - 32'h0400_0000);
  endtask

  task automatic testHold();
    logic [31:0] p0;
    p0 = loPhase;
    sampleValid = 1'b1; loValid = 1'b0; sample = 16'h7fff; loCos = 32'h7fff_0000;
    repeat (3) @(negedge clk);
    sampleValid = 1'b0;
    check("R4 phase held", loPhase, p0);
    check("R4 no result", {31'd0, resultValid}, 32'd0);
    check("R4 I unchanged", iOut, lastI);
    pushBatch(2);  // model excludes the offered sample
  endtask

  task automatic testSameCycle();
    startBatch(32'h0, 32'h0100_0000, 32'h0010_0000, 8'd1, 5'd4, 1'b1);
    check("R2 sample with start ignored", loPhase, 32'h0100_0000);
    pushBatch(3);
  endtask

  task automatic testKZeroWrap();
    startBatch(32'hf000_0000, 32'h1000_0000, 32'h7000_0000, 8'd3, 5'd0, 1'b0);
    check("R2 harmonic 3 wraps", loPhase, 32'h2000_0000);
    pushBatch(4);
    check("R9 R3 wrapped phase", loPhase, 32'h2000_0000 + 32'd4 * 32'h5000_0000);
  endtask

  task automatic testPersist();
    startBatch(32'h0, 32'h0, 32'h0800_0000, 8'd1, 5'd2, 1'b0);
    pushBatch(5);
    startBatch(32'h0, 32'h0, 32'h0800_0000, 8'd1, 5'd2, 1'b0);
    pushBatch(6);  // R8: model carries filter state across the second start
  endtask

  initial begin
    #(PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testFundamental();
    testHold();
    testSameCycle();
    testKZeroWrap();
    testPersist();
    doReset();
    check("R1 I cleared by reset", iOut, 32'd0);
    pushBatch(7);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule